// File: doc/BRIEF.md
# Coherent Read Response Completion Combiner

On a snooping, split-transaction system bus, a coherent read is finished only when its read response ends. Every snooping agent must first learn the state of the target line from its own processor. This block is the bus-side logic that collects those per-agent reports. It keeps the response open until the last agent has reported. It then gives the requester a combined verdict: whether the line is to be installed shared or exclusive, and whether the line data comes from memory or from an agent that holds a dirty copy.

When exactly one agent claims the line (a takeover), the block redirects the data source to that agent. In the same cycle it also starts the write-back of that data to memory. Several takeovers in one response are reported as a protocol error. A programmable cycle limit closes a response whose agents never all report, and flags a timeout.

Top module: `rrc_combiner`

## Requirements
- R1: A start (`rsp_start` high while neither `rsp_busy` nor `rsp_complete` is high) raises `rsp_busy` from the next cycle. `rsp_busy` stays high until every agent has raised its `agt_done` bit. `rsp_complete` is then high for exactly one cycle, the cycle after the clock edge at which the last outstanding `agt_done` bit was sampled, and `rsp_busy` is low in that cycle.
- R2: An agent's `agt_shared` and `agt_takeover` bits are taken only in the cycle in which its first `agt_done` of the current response is sampled. These bits are ignored in any other cycle and from any agent whose done bit is low.
- R3: For an ordinary read (`rsp_excl` low at start), `rsp_shared` in the complete cycle is the OR of the captured shared bits (1 = install shared, 0 = install exclusive).
- R4: For a read-exclusive (`rsp_excl` high at start), captured shared bits are ignored and `rsp_shared` is 0.
- R5: If exactly one agent's captured takeover bit is set, `rsp_src_agent` is 1 and `rsp_src_idx` gives that agent's index (bit position in `agt_done`). Otherwise `rsp_src_agent` is 0 (data from memory) and `rsp_src_idx` is 0.
- R6: `wb_start` is high in the complete cycle exactly when `rsp_src_agent` is high, so the memory write-back starts in the same cycle that the agent's data is delivered.
- R7: If two or more captured takeover bits are set, `rsp_proto_err` is high in the complete cycle, the source is memory and `wb_start` stays low.
- R8: With `tmo_limit` = L > 0, a response still missing reports after L busy cycles completes in the cycle after the L-th busy cycle with `rsp_timeout_err` high and all other result outputs 0. If the last report arrives in busy cycle L itself, the response completes normally. L = 0 disables the timeout.
- R9: Done flags are cleared at each start. Reports given while idle are ignored, and a start pulse while busy or complete is ignored.
- R10: During and after reset, `rsp_busy`, `rsp_complete` and all result outputs are 0.
- R11: Outside the complete cycle, `rsp_shared`, `rsp_src_agent`, `rsp_src_idx`, `wb_start`, `rsp_proto_err` and `rsp_timeout_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_start | input | 1 | Pulse that opens a read response |
| rsp_excl | input | 1 | Read-exclusive flag, sampled with the start |
| tmo_limit | input | TMO_W | Busy-cycle limit, 0 disables |
| agt_done | input | AGENTS | Per-agent report-valid bits |
| agt_shared | input | AGENTS | Per-agent shared indication |
| agt_takeover | input | AGENTS | Per-agent takeover indication |
| rsp_busy | output | 1 | Response held open |
| rsp_complete | output | 1 | One-cycle completion strobe |
| rsp_shared | output | 1 | Final line state: 1 shared, 0 exclusive |
| rsp_src_agent | output | 1 | Data source is an agent (1) or memory (0) |
| rsp_src_idx | output | IDX_W | Index of the supplying agent |
| wb_start | output | 1 | Start of the memory write-back of agent data |
| rsp_proto_err | output | 1 | More than one takeover seen |
| rsp_timeout_err | output | 1 | Response closed by the cycle limit |

## Verification
A done flag stuck set or left uncleared shows up as a completion that is too early, which is visible at `rsp_complete` within the response it corrupts. A flag that never sets shows up as a stretched response or a timeout. A wrongly captured shared or takeover bit shows up as a wrong line state, source or write-back strobe in the single complete cycle of that same response. The scoreboard therefore compares each completion's full result and its latency in cycles against values computed from the report schedule. This includes schedules where idle reports, late noise and a repeated start try to disturb the flags.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DONE    = 2'd2
  } rrc_state_e;

  typedef struct packed {
    logic shared;
    logic src_agent;
    logic wb;
    logic perr;
    logic terr;
  } rrc_result_t;
endpackage

// File: rtl/rrc_collect.sv
module rrc_collect #(
  parameter int AGENTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture_en,
  input  logic [AGENTS-1:0] agt_done,
  input  logic [AGENTS-1:0] agt_shared,
  input  logic [AGENTS-1:0] agt_takeover,
  output logic [AGENTS-1:0] seen_nx,
  output logic [AGENTS-1:0] shared_nx,
  output logic [AGENTS-1:0] tk_nx
);
  logic [AGENTS-1:0] seen_q, shared_q, tk_q;

  for (genvar i = 0; i < AGENTS; i++) begin : g_agent
    logic first_rpt;
    logic seen_d, shared_d, tk_d, en;

    assign first_rpt = capture_en & agt_done[i] & ~seen_q[i];

    always_comb begin
      en       = clear | first_rpt;
      seen_d   = ~clear;
      shared_d = ~clear & agt_shared[i];
      tk_d     = ~clear & agt_takeover[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[i]   <= 1'b0;
        shared_q[i] <= 1'b0;
        tk_q[i]     <= 1'b0;
      end else if (en) begin
        seen_q[i]   <= seen_d;
        shared_q[i] <= shared_d;
        tk_q[i]     <= tk_d;
      end
    end

    assign seen_nx[i]   = seen_q[i] | first_rpt;
    assign shared_nx[i] = first_rpt ? agt_shared[i]   : shared_q[i];
    assign tk_nx[i]     = first_rpt ? agt_takeover[i] : tk_q[i];

    assert_seen_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && seen_q[i]) |=> (seen_q[i] && $stable(shared_q[i]) && $stable(tk_q[i])));
  end

  assert_clear_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (seen_q == '0));
endmodule

// File: rtl/rrc_merge.sv
module rrc_merge #(
  parameter int AGENTS = 4,
  localparam int IDX_W = (AGENTS > 1) ? $clog2(AGENTS) : 1,
  localparam int CNT_W = $clog2(AGENTS + 1)
) (
  input  logic [AGENTS-1:0] shared_v,
  input  logic [AGENTS-1:0] tk_v,
  input  logic              excl,
  output logic              line_shared,
  output logic              tk_one,
  output logic              tk_multi,
  output logic [IDX_W-1:0]  tk_idx
);
  logic [CNT_W-1:0] tk_cnt;

  always_comb begin
    tk_cnt = '0;
    tk_idx = '0;
    for (int i = AGENTS - 1; i >= 0; i--) begin
      tk_cnt = tk_cnt + CNT_W'(tk_v[i]);
      if (tk_v[i]) tk_idx = IDX_W'(i);
    end
    tk_one      = (tk_cnt == CNT_W'(1));
    tk_multi    = (tk_cnt > CNT_W'(1));
    line_shared = ~excl & (|shared_v);
  end
endmodule

// File: rtl/rrc_timer.sv
module rrc_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear | (run & ~(&cnt_q));
    cnt_d  = clear ? '0 : cnt_q + TMO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run & (limit != '0) & (cnt_q >= limit - TMO_W'(1));

  assert_timer_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/rrc_combiner.sv
module rrc_combiner
  import rrc_pkg::*;
#(
  parameter int AGENTS = 4,
  parameter int TMO_W  = 8,
  localparam int IDX_W = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_start,
  input  logic              rsp_excl,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [AGENTS-1:0] agt_done,
  input  logic [AGENTS-1:0] agt_shared,
  input  logic [AGENTS-1:0] agt_takeover,
  output logic              rsp_busy,
  output logic              rsp_complete,
  output logic              rsp_shared,
  output logic              rsp_src_agent,
  output logic [IDX_W-1:0]  rsp_src_idx,
  output logic              wb_start,
  output logic              rsp_proto_err,
  output logic              rsp_timeout_err
);
  rrc_state_e        state_q, state_d;
  logic              excl_q;
  rrc_result_t       res_q, res_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              accept, collecting, all_in, tmo, finish;
  logic [AGENTS-1:0] seen_nx, shared_nx, tk_nx;
  logic              line_shared, tk_one, tk_multi;
  logic [IDX_W-1:0]  tk_idx;

  assign accept     = (state_q == ST_IDLE) & rsp_start;
  assign collecting = (state_q == ST_COLLECT);

  rrc_collect #(.AGENTS(AGENTS)) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture_en(collecting),
    .agt_done(agt_done), .agt_shared(agt_shared), .agt_takeover(agt_takeover),
    .seen_nx(seen_nx), .shared_nx(shared_nx), .tk_nx(tk_nx)
  );

  rrc_merge #(.AGENTS(AGENTS)) u_merge (
    .shared_v(shared_nx), .tk_v(tk_nx), .excl(excl_q),
    .line_shared(line_shared), .tk_one(tk_one), .tk_multi(tk_multi), .tk_idx(tk_idx)
  );

  rrc_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(collecting),
    .limit(tmo_limit), .expired(tmo)
  );

  assign all_in = &seen_nx;
  assign finish = collecting & (all_in | tmo);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (rsp_start) state_d = ST_COLLECT;
      ST_COLLECT: if (finish)    state_d = ST_DONE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  // result for the closing cycle; a complete report set wins over the limit
  always_comb begin
    res_d = '0;
    idx_d = '0;
    if (all_in) begin
      res_d.shared    = line_shared;
      res_d.src_agent = tk_one;
      res_d.wb        = tk_one;
      res_d.perr      = tk_multi;
      idx_d           = tk_one ? tk_idx : '0;
    end else begin
      res_d.terr      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      excl_q <= 1'b0;
    else if (accept) excl_q <= rsp_excl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (finish) begin
      res_q <= res_d;
      idx_q <= idx_d;
    end
  end

  assign rsp_busy        = collecting;
  assign rsp_complete    = (state_q == ST_DONE);
  assign rsp_shared      = rsp_complete & res_q.shared;
  assign rsp_src_agent   = rsp_complete & res_q.src_agent;
  assign rsp_src_idx     = rsp_complete ? idx_q : '0;
  assign wb_start        = rsp_complete & res_q.wb;
  assign rsp_proto_err   = rsp_complete & res_q.perr;
  assign rsp_timeout_err = rsp_complete & res_q.terr;

  assert_hold_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_busy && !all_in && !tmo) |=> rsp_busy);
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_complete |=> !rsp_complete);
  assert_excl_not_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_complete && excl_q) |-> !rsp_shared);
  assert_takeover_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && tk_one) |-> tk_nx[tk_idx]);
  assert_wb_with_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_start |-> (rsp_complete && rsp_src_agent));
  assert_multi_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_proto_err |-> (!wb_start && !rsp_src_agent));
  assert_timeout_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout_err |-> (!rsp_shared && !wb_start && !rsp_proto_err));
  assert_quiet_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_complete |-> !(rsp_shared || rsp_src_agent || wb_start || rsp_proto_err || rsp_timeout_err));
endmodule

// File: tb/tb_rrc_combiner.sv
`timescale 1ns/1ps
module tb_rrc_combiner;
  localparam int N = 4;
  localparam int TW = 8;

  logic          clk, rst_n;
  logic          rsp_start, rsp_excl;
  logic [TW-1:0] tmo_limit;
  logic [N-1:0]  agt_done, agt_shared, agt_takeover;
  logic          rsp_busy, rsp_complete, rsp_shared, rsp_src_agent;
  logic [1:0]    rsp_src_idx;
  logic          wb_start, rsp_proto_err, rsp_timeout_err;

  rrc_combiner #(.AGENTS(N), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .rsp_start(rsp_start), .rsp_excl(rsp_excl),
    .tmo_limit(tmo_limit), .agt_done(agt_done), .agt_shared(agt_shared),
    .agt_takeover(agt_takeover), .rsp_busy(rsp_busy), .rsp_complete(rsp_complete),
    .rsp_shared(rsp_shared), .rsp_src_agent(rsp_src_agent), .rsp_src_idx(rsp_src_idx),
    .wb_start(wb_start), .rsp_proto_err(rsp_proto_err), .rsp_timeout_err(rsp_timeout_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [5:0] res;  // {shared, src_agent, idx[1:0], wb, perr} ++ timeout below
    logic       te;
    int         lat;
    string      tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_err = 0;
  int    cyc = 0;
  int    rep_c [N];
  logic [N-1:0] sh_m, tk_m;
  bit    done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // cycles since the accepted start edge
  always @(posedge clk)
    if (rsp_start && !rsp_busy && !rsp_complete) cyc <= 0;
    else cyc <= cyc + 1;

  // monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (rst_n && rsp_complete) begin
      if (sb_q.size() == 0) chk(0, "R1", "unexpected completion", 1, 0);
      else begin
        exp_t e;
        logic [5:0] act;
        e = sb_q.pop_front();
        act = {rsp_shared, rsp_src_agent, rsp_src_idx, wb_start, rsp_proto_err};
        chk(act == e.res, e.tag, "result", int'(act), int'(e.res));
        chk(rsp_timeout_err == e.te, e.tag, "timeout flag", int'(rsp_timeout_err), int'(e.te));
        chk(cyc == e.lat, e.tag, "latency", cyc, e.lat);
        chk(!rsp_busy, "R1", "busy in complete cycle", int'(rsp_busy), 0);
      end
    end
  end

  task automatic run(input bit excl, input int lim, input bit noisy,
                     input bit idle_noise, input bit restart, input string tag);
    exp_t e;
    int   maxr = 0;
    bit   all_r = 1;
    int   ntk = 0, tki = 0;
    bit   anysh = 0;
    for (int i = 0; i < N; i++) begin
      if (rep_c[i] == 0) all_r = 0;
      if (rep_c[i] > maxr) maxr = rep_c[i];
      if (tk_m[i]) begin ntk++; if (ntk == 1) tki = i; end
      if (sh_m[i]) anysh = 1;
    end
    e.tag = tag;
    if (all_r && (lim == 0 || maxr <= lim)) begin
      e.lat = maxr;
      e.te  = 0;
      e.res = {(!excl && anysh), (ntk == 1), (ntk == 1) ? 2'(tki) : 2'd0, (ntk == 1), (ntk > 1)};
    end else begin
      e.lat = lim;
      e.te  = 1;
      e.res = '0;
    end
    tmo_limit = TW'(lim);
    @(negedge clk);
    if (idle_noise) begin
      agt_done = '1; agt_takeover = '1; agt_shared = '1;
      @(negedge clk);
      agt_done = '0; agt_takeover = '0; agt_shared = '0;
    end
    rsp_start = 1; rsp_excl = excl;
    sb_q.push_back(e);
    @(negedge clk);
    rsp_start = 0; rsp_excl = 0;
    for (int c = 1; c <= e.lat; c++) begin
      chk(rsp_busy, "R1", "busy while collecting", int'(rsp_busy), 1);
      rsp_start = restart && (c == 1);
      for (int i = 0; i < N; i++) begin
        agt_done[i]     = (rep_c[i] == c);
        agt_shared[i]   = (rep_c[i] == c) ? sh_m[i] : noisy;
        agt_takeover[i] = (rep_c[i] == c) ? tk_m[i] : noisy;
      end
      @(negedge clk);
    end
    rsp_start = 0; agt_done = '0; agt_shared = '0; agt_takeover = '0;
    @(negedge clk);
    chk(!rsp_complete && !rsp_busy, "R1", "after completion", int'({rsp_busy, rsp_complete}), 0);
    chk({rsp_shared, rsp_src_agent, rsp_src_idx, wb_start, rsp_proto_err, rsp_timeout_err} == '0,
        "R11", "outputs outside complete", int'({rsp_shared, rsp_src_agent, wb_start}), 0);
  endtask

  task automatic setr(input int a, input int b, input int c, input int d,
                      input logic [N-1:0] sh, input logic [N-1:0] tk);
    rep_c[0] = a; rep_c[1] = b; rep_c[2] = c; rep_c[3] = d;
    sh_m = sh; tk_m = tk;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rsp_start = 0; rsp_excl = 0; tmo_limit = '0;
    agt_done = '0; agt_shared = '0; agt_takeover = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_busy && !rsp_complete && !rsp_shared && !wb_start && !rsp_timeout_err,
        "R10", "reset outputs", int'({rsp_busy, rsp_complete}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_busy && !rsp_complete, "R10", "idle after reset", int'({rsp_busy, rsp_complete}), 0);

    setr(1, 1, 1, 1, 4'b0000, 4'b0000); run(0, 0, 0, 0, 0, "R1 all at once");
    setr(1, 3, 2, 5, 4'b0100, 4'b0000); run(0, 0, 0, 0, 0, "R3 staggered shared");
    setr(2, 1, 4, 3, 4'b0000, 4'b0000); run(0, 20, 1, 0, 0, "R2 noise ignored");
    setr(1, 2, 1, 2, 4'b1011, 4'b0000); run(1, 0, 0, 0, 0, "R4 exclusive");
    setr(2, 1, 3, 2, 4'b1000, 4'b1000); run(0, 0, 0, 0, 0, "R5 R6 takeover agent3");
    setr(1, 1, 2, 1, 4'b0010, 4'b0010); run(1, 0, 1, 0, 0, "R5 R6 excl takeover agent1");
    setr(1, 2, 3, 1, 4'b0101, 4'b0101); run(0, 0, 0, 0, 0, "R7 two takeovers");
    setr(1, 0, 2, 1, 4'b0001, 4'b0100); run(0, 6, 0, 0, 0, "R8 timeout missing agent");
    setr(7, 2, 1, 3, 4'b0000, 4'b0000); run(0, 4, 0, 0, 0, "R8 report beyond limit");
    setr(4, 2, 1, 4, 4'b0001, 4'b0000); run(0, 4, 0, 0, 0, "R8 report at limit");
    setr(9, 1, 1, 1, 4'b0000, 4'b0001); run(0, 0, 0, 0, 0, "R8 limit zero disabled");
    setr(3, 3, 2, 3, 4'b0010, 4'b0000); run(0, 0, 0, 1, 1, "R9 idle reports and restart");

    chk(sb_q.size() == 0, "R1", "pending expected results", sb_q.size(), 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule